// File: doc/BRIEF.md
# Erase-Block Protection Register Bank

This block keeps one small protection register for every erase block of a flash array and answers, for each array access, whether that access may go ahead. Each register carries three live bits: a read lock, a write lock and a lock-down bit. Once the lock-down bit is set, the register is frozen until the next reset. Two hardware inputs add protection on top of the registers. The top-lock input guards the highest-numbered block. The write-protect input guards every other block.

The command decoder presents an access as a block index plus an operation code. One cycle later the bank returns a registered verdict. A denied program or erase raises a protection-error flag, which the decoder copies into its block-protected status bit. A read that is allowed passes the array byte through. A read of a read-locked block returns zero. Software reaches the registers through a plain write port and a registered read port, each indexed by block number.

Top module: `lockbank_top`

## Requirements
- R1: After reset every register reads 01h. The bit layout is: bit 0 write lock, bit 1 lock-down, bit 2 read lock, bits 7..3 reserved.
- R2: A write to an unfrozen register stores data bits 2..0. Reserved bits are ignored and always read as 0. `reg_rdata` shows the register named by `reg_rd_idx` one clock after the index is presented.
- R3: After the lock-down bit is stored, every later write to that register is ignored until reset, including a write that tries to clear lock-down. Other registers stay writable.
- R4: A program (op 1) or erase (op 2 or 3) to a write-locked block gives `resp_allow`=0 and `resp_prot`=1 one clock after the access. To an unlocked block with no active pin it gives `resp_allow`=1 and `resp_prot`=0. `resp_valid` is high exactly one clock after each `acc_valid`.
- R5: While `top_lock` is 1, program and erase to block NBLK-1 are denied with `resp_prot`=1, whatever the register holds. Other blocks are unaffected, and the stored bits do not change.
- R6: While `wr_protect` is 1, program and erase to blocks 0..NBLK-2 are denied with `resp_prot`=1. Block NBLK-1 is unaffected, and the stored bits do not change.
- R7: A read (op 0) of a read-locked block gives `resp_allow`=0, `resp_prot`=0 and `resp_data`=00h. A read of a block that is not read-locked gives `resp_allow`=1 and returns `arr_data`.
- R8: Reads are not affected by the write lock or by either hardware pin.
- R9: An index of NBLK or above is out of range. Writes to it are ignored, register reads of it return 00h, and accesses to it are denied (`resp_prot`=1 for program and erase).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | IW | Block index of register write |
| reg_wdata | input | 8 | Register write data |
| reg_rd_idx | input | IW | Block index of register read |
| reg_rdata | output | 8 | Registered register read data |
| top_lock | input | 1 | Forces write protection of top block |
| wr_protect | input | 1 | Forces write protection of all other blocks |
| acc_valid | input | 1 | Array access request |
| acc_idx | input | IW | Block addressed by the access |
| acc_op | input | 2 | 0 read, 1 program, 2/3 erase |
| arr_data | input | 8 | Array byte for a read |
| resp_valid | output | 1 | Verdict valid, one clock after request |
| resp_allow | output | 1 | Access permitted |
| resp_prot | output | 1 | Program/erase refused by protection |
| resp_data | output | 8 | Gated read byte |

## Verification
Every result of this bank is registered and is due on the first rising edge after its stimulus. An access verdict and its gated byte appear one clock after `acc_valid`. Register read data appears one clock after `reg_rd_idx` changes. A write becomes visible to reads and verdicts presented after the edge that captured it. The bench changes inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and observation. Lock-down, pin and range checks read the registers back through the read port to show that the stored bits did not change.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_ERS2  = 2'd3
  } op_e;

  typedef struct packed {
    logic rd_lock;
    logic down;
    logic wr_lock;
  } lock_t;

  localparam lock_t LOCK_RST = '{rd_lock: 1'b0, down: 1'b0, wr_lock: 1'b1};

  function automatic logic [7:0] lock_to_byte(lock_t l);
    return {5'b00000, l};
  endfunction
endpackage

// File: rtl/lock_store.sv
module lock_store
  import lockbank_pkg::*;
#(
  parameter int NBLK = 50,
  parameter int IW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output lock_t         rd_lock,
  output logic          rd_hit,
  input  logic [IW-1:0] acc_idx,
  output lock_t         acc_lock,
  output logic          acc_hit
);
  lock_t regs [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= LOCK_RST;
      else if (wr_en && (int'(wr_idx) == g) && !regs[g].down)
        regs[g] <= wr_data[2:0];
    end
  end

  always_comb begin
    rd_hit   = int'(rd_idx) < NBLK;
    acc_hit  = int'(acc_idx) < NBLK;
    rd_lock  = rd_hit  ? regs[rd_idx]  : '0;
    acc_lock = acc_hit ? regs[acc_idx] : '0;
  end
endmodule

// File: rtl/lock_eval.sv
module lock_eval
  import lockbank_pkg::*;
(
  input  lock_t      lock,
  input  logic       hit,
  input  logic       is_top,
  input  logic [1:0] op,
  input  logic       top_lock,
  input  logic       wr_protect,
  output logic       allow,
  output logic       prot
);
  logic modify;
  logic pin_force;

  always_comb begin
    modify    = (op_e'(op) != OP_READ);
    pin_force = is_top ? top_lock : wr_protect;
    if (!hit) begin
      allow = 1'b0;
    end else if (modify) begin
      allow = !lock.wr_lock && !pin_force;
    end else begin
      allow = !lock.rd_lock;
    end
    prot = modify && !allow;
  end
endmodule

// File: rtl/lockbank_top.sv
module lockbank_top
  import lockbank_pkg::*;
#(
  parameter int NBLK = 50,
  parameter int IW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [IW-1:0] reg_wr_idx,
  input  logic [7:0]    reg_wdata,
  input  logic [IW-1:0] reg_rd_idx,
  output logic [7:0]    reg_rdata,
  input  logic          top_lock,
  input  logic          wr_protect,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  input  logic [1:0]    acc_op,
  input  logic [7:0]    arr_data,
  output logic          resp_valid,
  output logic          resp_allow,
  output logic          resp_prot,
  output logic [7:0]    resp_data
);
  localparam logic [IW-1:0] TOP_IDX = IW'(NBLK - 1);

  lock_t rd_lock, acc_lock;
  logic  rd_hit, acc_hit;
  logic  ev_allow, ev_prot;

  lock_store #(.NBLK(NBLK), .IW(IW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wdata),
    .rd_idx(reg_rd_idx), .rd_lock(rd_lock), .rd_hit(rd_hit),
    .acc_idx(acc_idx), .acc_lock(acc_lock), .acc_hit(acc_hit)
  );

  lock_eval u_eval (
    .lock(acc_lock), .hit(acc_hit), .is_top(acc_idx == TOP_IDX),
    .op(acc_op), .top_lock(top_lock), .wr_protect(wr_protect),
    .allow(ev_allow), .prot(ev_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= 8'h00;
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_prot  <= 1'b0;
      resp_data  <= 8'h00;
    end else begin
      reg_rdata  <= rd_hit ? lock_to_byte(rd_lock) : 8'h00;
      resp_valid <= acc_valid;
      resp_allow <= acc_valid && ev_allow;
      resp_prot  <= acc_valid && ev_prot;
      resp_data  <= (acc_valid && ev_allow && op_e'(acc_op) == OP_READ) ? arr_data : 8'h00;
    end
  end
endmodule

// File: rtl/lockbank_checker.sv
module lockbank_checker #(
  parameter int NBLK = 50,
  parameter int IW   = $clog2(NBLK)
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    reg_rdata,
  input logic          top_lock,
  input logic          wr_protect,
  input logic          acc_valid,
  input logic [IW-1:0] acc_idx,
  input logic [1:0]    acc_op,
  input logic          resp_valid,
  input logic          resp_allow,
  input logic          resp_prot,
  input logic [7:0]    resp_data
);
  localparam logic [IW-1:0] TOP_IDX = IW'(NBLK - 1);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:3] == 5'b0); // R2

  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> resp_valid); // R4

  AST_PROT_DENIES: assert property (@(posedge clk) disable iff (rst)
    resp_prot |-> (resp_valid && !resp_allow)); // R4

  AST_TOP_PIN: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_op != 2'd0 && acc_idx == TOP_IDX && top_lock)
      |=> (resp_prot && !resp_allow)); // R5

  AST_WP_PIN: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_op != 2'd0 && int'(acc_idx) < NBLK - 1 && wr_protect)
      |=> (resp_prot && !resp_allow)); // R6

  AST_READ_NO_PROT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_op == 2'd0) |=> !resp_prot); // R7

  AST_DENY_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_allow) |-> resp_data == 8'h00); // R7
endmodule

bind lockbank_top lockbank_checker #(.NBLK(NBLK), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata),
  .top_lock(top_lock), .wr_protect(wr_protect),
  .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_op(acc_op),
  .resp_valid(resp_valid), .resp_allow(resp_allow),
  .resp_prot(resp_prot), .resp_data(resp_data)
);

// File: tb/lockbank_top_test.sv
`timescale 1ns/1ps
module lockbank_top_test;
  localparam int NBLK = 50;
  localparam int IW   = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [IW-1:0] reg_wr_idx = '0;
  logic [7:0]    reg_wdata = '0;
  logic [IW-1:0] reg_rd_idx = '0;
  logic [7:0]    reg_rdata;
  logic          top_lock = 1'b0;
  logic          wr_protect = 1'b0;
  logic          acc_valid = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic [1:0]    acc_op = '0;
  logic [7:0]    arr_data = '0;
  logic          resp_valid, resp_allow, resp_prot;
  logic [7:0]    resp_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lockbank_top #(.NBLK(NBLK), .IW(IW)) uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = IW'(idx); reg_wdata = 8'(data);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int idx, output int val);
    @(negedge clk);
    reg_rd_idx = IW'(idx);
    @(negedge clk);
    val = reg_rdata;
  endtask

  // returns {valid, allow, prot, data}
  task automatic acc(int idx, int op, int data, output int v, output int a, output int p, output int d);
    @(negedge clk);
    acc_valid = 1'b1; acc_idx = IW'(idx); acc_op = 2'(op); arr_data = 8'(data);
    @(negedge clk);
    v = resp_valid; a = resp_allow; p = resp_prot; d = resp_data;
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    int r;
    rd(0, r);          chk("R1 blk0", r, 8'h01);
    rd(NBLK-1, r);     chk("R1 top", r, 8'h01);
    rd(17, r);         chk("R1 mid", r, 8'h01);
  endtask

  task automatic t_write();
    int r;
    wr(3, 8'hF8);      rd(3, r); chk("R2 reserved ignored", r, 8'h00);
    wr(3, 8'hFD);      rd(3, r); chk("R2 store bits", r, 8'h05);
    wr(4, 8'h00);      rd(4, r); chk("R2 clear", r, 8'h00);
  endtask

  task automatic t_access();
    int v, a, p, d;
    acc(5, 1, 0, v, a, p, d);
    chk("R4 valid", v, 1); chk("R4 locked prog allow", a, 0); chk("R4 locked prog prot", p, 1);
    acc(4, 2, 0, v, a, p, d);
    chk("R4 unlocked erase allow", a, 1); chk("R4 unlocked erase prot", p, 0);
    acc(5, 3, 0, v, a, p, d);
    chk("R4 op3 locked prot", p, 1);
    @(negedge clk);
    chk("R4 valid drops", resp_valid, 0);
  endtask

  task automatic t_lockdown();
    int r;
    wr(7, 8'h02);      rd(7, r); chk("R3 set down", r, 8'h02);
    wr(7, 8'h00);      rd(7, r); chk("R3 clear ignored", r, 8'h02);
    wr(7, 8'h05);      rd(7, r); chk("R3 write ignored", r, 8'h02);
    wr(8, 8'h04);      rd(8, r); chk("R3 neighbour writable", r, 8'h04);
  endtask

  task automatic t_pins();
    int v, a, p, d, r;
    wr(NBLK-1, 8'h00); wr(10, 8'h00);
    top_lock = 1'b1;
    acc(NBLK-1, 1, 0, v, a, p, d); chk("R5 top denied", p, 1);
    acc(10, 1, 0, v, a, p, d);     chk("R5 other allowed", a, 1);
    rd(NBLK-1, r);                 chk("R5 stored unchanged", r, 8'h00);
    top_lock = 1'b0;
    acc(NBLK-1, 2, 0, v, a, p, d); chk("R5 released", a, 1);
    wr_protect = 1'b1;
    acc(10, 2, 0, v, a, p, d);     chk("R6 block denied", p, 1);
    acc(NBLK-1, 1, 0, v, a, p, d); chk("R6 top unaffected", a, 1);
    rd(10, r);                     chk("R6 stored unchanged", r, 8'h00);
    // R8: reads unaffected by pins and write lock
    top_lock = 1'b1;
    acc(10, 0, 8'h3C, v, a, p, d);     chk("R8 read under wp", d, 8'h3C);
    acc(NBLK-1, 0, 8'hC3, v, a, p, d); chk("R8 read under top", d, 8'hC3);
    acc(5, 0, 8'h77, v, a, p, d);      chk("R8 read of write-locked", d, 8'h77);
    top_lock = 1'b0; wr_protect = 1'b0;
  endtask

  task automatic t_readlock();
    int v, a, p, d;
    acc(8, 0, 8'hA5, v, a, p, d);
    chk("R7 locked allow", a, 0); chk("R7 locked prot", p, 0); chk("R7 locked data", d, 8'h00);
    acc(4, 0, 8'h5A, v, a, p, d);
    chk("R7 open allow", a, 1); chk("R7 open data", d, 8'h5A);
  endtask

  task automatic t_range();
    int v, a, p, d, r;
    wr(NBLK, 8'h00);
    rd(NBLK, r);  chk("R9 read", r, 8'h00);
    rd(63, r);    chk("R9 read 63", r, 8'h00);
    acc(NBLK, 1, 0, v, a, p, d); chk("R9 prog prot", p, 1);
    acc(63, 0, 8'h11, v, a, p, d); chk("R9 read allow", a, 0); chk("R9 read data", d, 0);
    rd(0, r);     chk("R9 blk0 untouched", r, 8'h01);
  endtask

  task automatic t_rereset();
    int r;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(7, r); chk("R1 lockdown cleared by reset", r, 8'h01);
    rd(8, r); chk("R1 reg8 reset", r, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata after reset", reg_rdata, 0);
    t_reset();
    t_write();
    t_access();
    t_lockdown();
    t_readlock();
    t_pins();
    t_range();
    t_rereset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule